// File: doc/BRIEF.md
# Parked Two-Master Bus Arbiter

This block decides which of two masters owns a shared external bus: an internal master and an external master. The internal master sits parked on the bus once it holds it. While no one else wants the bus it keeps the grant and may start access after access with no request phase. The external master asks with a bus-request line and is answered with a bus-grant line. A shared busy line is read back as an input. The internal side drives that line through a value and an enable output. Start and acknowledge strobes on the bus mark where each transaction begins and ends.

Both request lines are registered before they take part in a decision. A two-bit field chooses the policy. Equal priority hands a tie to whichever master used the bus least recently. The other two settings make one master always win a contested decision. A transaction that has started, or a grant that has been issued, is never taken back. Handover happens only at a transaction boundary.

Top module: `parked_bus_arbiter`

## Requirements
- R1: After reset the grant outputs `int_gnt_o` and `ext_bg_o` are low and `bb_oe_o` is low. The last-owner record points at the external master, so the internal master wins the first equal-priority tie.
- R2: `ext_bg_o` rises only when `ext_br_i` was high at a rising edge at least one full clock earlier. From an idle or parked-idle bus, a request that is first sampled at edge k is granted from edge k+1.
- R3: While it holds the grant, the internal master may issue back-to-back transactions with no new request phase. It keeps `int_gnt_o` while the external master does not request, even with `int_req_i` low.
- R4: From an idle bus with `bb_i` low, an internal request first sampled at edge k gives `int_gnt_o` from edge k+1.
- R5: Under equal priority (`prio_cfg_i` 2'b00, and 2'b11 treated the same), when both registered requests are present at a decision, the master that did not finish the most recent transaction wins. The record is updated on each `ta_i` during an ownership.
- R6: Under equal priority the current owner gives up the bus after its current transaction when the other master requests and wins under R5.
- R7: With `prio_cfg_i` 2'b01 the internal master keeps the bus as long as its registered request is present. The external master is granted only at a boundary where the internal request is absent.
- R8: With `prio_cfg_i` 2'b10 the external master is granted at the first boundary where its registered request is present, whatever the internal request.
- R9: No pre-emption. While a transaction is in flight (from the `ts_i` cycle through the `ta_i` cycle), or while `ext_bg_o` is high, the ownership does not change.
- R10: `ext_bg_o` goes low in the cycle after `bb_i` is sampled high during a grant. The external master keeps the bus while `bb_i` is high. Ownership is released at the first edge with `bb_i` low and no transaction in flight.
- R11: `bb_oe_o` is high exactly while the internal master owns the bus. `bb_o` is high while the internal master's transaction is in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prio_cfg_i | input | 2 | Priority policy: 00 equal, 01 internal first, 10 external first, 11 equal |
| int_req_i | input | 1 | Internal master wants the bus |
| int_gnt_o | output | 1 | Internal master owns the bus and may start |
| ext_br_i | input | 1 | External bus request |
| ext_bg_o | output | 1 | External bus grant |
| bb_i | input | 1 | Sampled bus-busy line |
| bb_o | output | 1 | Bus-busy value driven by the internal side |
| bb_oe_o | output | 1 | Drive enable for `bb_o` |
| ts_i | input | 1 | Transaction start strobe |
| ta_i | input | 1 | Transaction acknowledge strobe |

## Verification
The policy logic is driven with simultaneous requests under every setting of the priority field, both from an idle bus and at a parked owner's boundary. Each case is placed where the least-recently-used answer differs from the fixed-priority answer, so a swapped or ignored setting shows up as a different winner. Back-to-back internal accesses with the request both held and dropped separate parking from re-arbitration. A long wait-state transaction with a competing higher-priority request, and a grant left unused while the other side requests, separate a correct no-pre-emption rule from an early handover. Request-to-grant distance is measured on every grant, which exposes any path that skips the sampling register.

// File: rtl/parked_arb_pkg.sv
package parked_arb_pkg;
  localparam int PRIO_W  = 2;
  localparam int N_REQ   = 2;
  localparam int REQ_INT = 0;
  localparam int REQ_EXT = 1;

  typedef enum logic [PRIO_W-1:0] {
    PRIO_EQUAL     = 2'b00,
    PRIO_INT_FIRST = 2'b01,
    PRIO_EXT_FIRST = 2'b10,
    PRIO_EQUAL_ALT = 2'b11
  } prio_e;

  typedef enum logic [1:0] {
    PICK_NONE,
    PICK_INT,
    PICK_EXT
  } pick_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INT,
    ST_EXT_GNT,
    ST_EXT_OWN
  } bus_st_e;
endpackage

// File: rtl/parked_arb_req_reg.sv
module parked_arb_req_reg #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] req_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q_o <= '0;
    else         req_q_o <= req_i;
  end
endmodule

// File: rtl/parked_arb_pick.sv
module parked_arb_pick
  import parked_arb_pkg::*;
(
  input  logic              int_req_i,
  input  logic              ext_req_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic              last_int_i,
  output pick_e             pick_o
);
  always_comb begin
    pick_o = PICK_NONE;
    case ({int_req_i, ext_req_i})
      2'b10: pick_o = PICK_INT;
      2'b01: pick_o = PICK_EXT;
      2'b11: begin
        case (prio_e'(prio_i))
          PRIO_INT_FIRST: pick_o = PICK_INT;
          PRIO_EXT_FIRST: pick_o = PICK_EXT;
          // equal: least recent user wins
          default:        pick_o = last_int_i ? PICK_EXT : PICK_INT;
        endcase
      end
      default: pick_o = PICK_NONE;
    endcase
  end
endmodule

// File: rtl/parked_arb_xfer.sv
module parked_arb_xfer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ts_i,
  input  logic ta_i,
  input  logic own_int_i,
  input  logic own_ext_i,
  output logic inflight_o,
  output logic last_int_o
);
  logic xfer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_q     <= 1'b0;
      last_int_o <= 1'b0;
    end else begin
      if (ta_i)      xfer_q <= 1'b0;
      else if (ts_i) xfer_q <= 1'b1;
      if (ta_i && (own_int_i || own_ext_i)) last_int_o <= own_int_i;
    end
  end

  assign inflight_o = xfer_q | ts_i;
endmodule

// File: rtl/parked_bus_arbiter.sv
module parked_bus_arbiter
  import parked_arb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PRIO_W-1:0] prio_cfg_i,
  input  logic              int_req_i,
  output logic              int_gnt_o,
  input  logic              ext_br_i,
  output logic              ext_bg_o,
  input  logic              bb_i,
  output logic              bb_o,
  output logic              bb_oe_o,
  input  logic              ts_i,
  input  logic              ta_i
);
  bus_st_e          state_q, state_d;
  logic [N_REQ-1:0] req_raw, req_q;
  logic             int_req_q, ext_req_q;
  logic             inflight, last_int;
  pick_e            pick;

  assign req_raw[REQ_INT] = int_req_i;
  assign req_raw[REQ_EXT] = ext_br_i;

  parked_arb_req_reg #(.N(N_REQ)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_raw),
    .req_q_o(req_q)
  );

  assign int_req_q = req_q[REQ_INT];
  assign ext_req_q = req_q[REQ_EXT];

  parked_arb_xfer u_xfer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ts_i      (ts_i),
    .ta_i      (ta_i),
    .own_int_i (state_q == ST_INT),
    .own_ext_i (state_q == ST_EXT_OWN),
    .inflight_o(inflight),
    .last_int_o(last_int)
  );

  parked_arb_pick u_pick (
    .int_req_i (int_req_q),
    .ext_req_i (ext_req_q),
    .prio_i    (prio_cfg_i),
    .last_int_i(last_int),
    .pick_o    (pick)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (!bb_i && !inflight) begin
          if (pick == PICK_INT)      state_d = ST_INT;
          else if (pick == PICK_EXT) state_d = ST_EXT_GNT;
        end
      end
      ST_INT: begin
        // parked: leave only at a boundary and only for the external side
        if (!inflight && pick == PICK_EXT) state_d = ST_EXT_GNT;
      end
      ST_EXT_GNT: begin
        if (bb_i) state_d = ST_EXT_OWN;
      end
      ST_EXT_OWN: begin
        if (!bb_i && !inflight) begin
          case (pick)
            PICK_INT: state_d = ST_INT;
            PICK_EXT: state_d = ST_EXT_GNT;
            default:  state_d = ST_IDLE;
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign int_gnt_o = (state_q == ST_INT);
  assign ext_bg_o  = (state_q == ST_EXT_GNT);
  assign bb_oe_o   = (state_q == ST_INT);
  assign bb_o      = (state_q == ST_INT) && inflight;
endmodule

// File: rtl/parked_bus_arbiter_chk.sv
module parked_bus_arbiter_chk
  import parked_arb_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PRIO_W-1:0] prio_cfg_i,
  input logic              int_req_i,
  input logic              int_gnt_o,
  input logic              ext_br_i,
  input logic              ext_bg_o,
  input logic              bb_i,
  input logic              bb_o,
  input logic              bb_oe_o,
  input logic              int_req_q,
  input logic              ext_req_q
);
  assert_bg_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_bg_o) |-> $past(ext_br_i, 2));

  assert_int_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_gnt_o) |-> $past(int_req_i, 2));

  assert_int_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio_cfg_i == 2'b01 && int_gnt_o && int_req_q) |=> int_gnt_o);

  assert_ext_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prio_cfg_i == 2'b10 && int_gnt_o && !bb_o && ext_req_q) |=> ext_bg_o);

  assert_no_preempt_xfer_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bb_oe_o && bb_o) |=> (int_gnt_o && !ext_bg_o));

  assert_grant_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_bg_o && !bb_i) |=> ext_bg_o);

  assert_bg_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_bg_o && bb_i) |=> !ext_bg_o);

  assert_parked_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_gnt_o) |-> $past(bb_oe_o && !bb_o));
endmodule

bind parked_bus_arbiter parked_bus_arbiter_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .prio_cfg_i(prio_cfg_i),
  .int_req_i (int_req_i),
  .int_gnt_o (int_gnt_o),
  .ext_br_i  (ext_br_i),
  .ext_bg_o  (ext_bg_o),
  .bb_i      (bb_i),
  .bb_o      (bb_o),
  .bb_oe_o   (bb_oe_o),
  .int_req_q (int_req_q),
  .ext_req_q (ext_req_q)
);

// File: tb/parked_bus_arbiter_test.sv
module parked_bus_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg = 2'b00;
  logic       int_req = 1'b0, ext_br = 1'b0, ext_bb = 1'b0, ts = 1'b0, ta = 1'b0;
  logic       int_gnt_o, ext_bg_o, bb_o, bb_oe_o;
  logic       bb_line;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  assign bb_line = (bb_oe_o & bb_o) | ext_bb;

  always #(CLK_PERIOD/2) clk = ~clk;

  parked_bus_arbiter uut (
    .clk_i(clk), .rst_ni(rst_n), .prio_cfg_i(cfg),
    .int_req_i(int_req), .int_gnt_o(int_gnt_o),
    .ext_br_i(ext_br), .ext_bg_o(ext_bg_o),
    .bb_i(bb_line), .bb_o(bb_o), .bb_oe_o(bb_oe_o),
    .ts_i(ts), .ta_i(ta)
  );

  function automatic void chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endfunction

  // reference model: 0 idle, 1 internal, 2 external granted, 3 external owns
  int m_st, m_xf, m_li, m_irq, m_erq, br_d1, br_d2;
  logic bg_prev = 1'b0;

  function automatic int pick(int ir, int er, int c, int li);
    if (ir == 0 && er == 0) return 0;
    if (er == 0) return 1;
    if (ir == 0) return 2;
    if (c == 1) return 1;
    if (c == 2) return 2;
    return (li != 0) ? 2 : 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_xf = 0; m_li = 0; m_irq = 0; m_erq = 0; br_d1 = 0; br_d2 = 0;
    end else begin
      int infl, p, nst, line;
      infl = (m_xf != 0 || ts) ? 1 : 0;
      line = ((m_st == 1 && infl != 0) || ext_bb) ? 1 : 0;
      p = pick(m_irq, m_erq, cfg, m_li);
      nst = m_st;
      if (m_st == 0 && line == 0 && infl == 0) nst = p;
      else if (m_st == 1 && infl == 0 && p == 2) nst = 2;
      else if (m_st == 2 && line != 0) nst = 3;
      else if (m_st == 3 && line == 0 && infl == 0) nst = p;
      if (ta && (m_st == 1 || m_st == 3)) m_li = (m_st == 1) ? 1 : 0;
      if (ta) m_xf = 0;
      else if (ts) m_xf = 1;
      m_irq = int_req; m_erq = ext_br; m_st = nst;
      br_d2 = br_d1; br_d1 = ext_br;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model ext_bg_o", ext_bg_o, (m_st == 2) ? 1 : 0);
      chk("R3 model int_gnt_o", int_gnt_o, (m_st == 1) ? 1 : 0);
      chk("R11 model bb_oe_o", bb_oe_o, (m_st == 1) ? 1 : 0);
      chk("R11 model bb_o", bb_o, (m_st == 1 && (m_xf != 0 || ts)) ? 1 : 0);
      if (ext_bg_o && !bg_prev) chk("R2 request sampled a clock before grant", br_d2, 1);
      bg_prev = ext_bg_o;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic int_xfer(int waits);
    ts = 1'b1; step(); ts = 1'b0;
    repeat (waits) step();
    ta = 1'b1; step(); ta = 1'b0;
  endtask

  task automatic ext_take();
    for (int i = 0; i < 50 && !ext_bg_o; i++) step();
    chk("R10 grant reached", ext_bg_o, 1);
    ext_bb = 1'b1; ext_br = 1'b0;
    step();
    chk("R10 grant dropped after busy", ext_bg_o, 0);
    ts = 1'b1; step(); ts = 1'b0;
    ta = 1'b1; step(); ta = 1'b0;
    ext_bb = 1'b0;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 reset int_gnt_o", int_gnt_o, 0);
    chk("R1 reset ext_bg_o", ext_bg_o, 0);
    chk("R1 reset bb_oe_o", bb_oe_o, 0);

    // internal from idle, then parked back-to-back
    int_req = 1'b1;
    step(); chk("R4 no grant after one edge", int_gnt_o, 0);
    step(); chk("R4 grant after second edge", int_gnt_o, 1);
    int_xfer(0);
    int_xfer(0);
    chk("R3 parked after back-to-back", int_gnt_o, 1);
    ts = 1'b1; step(); ts = 1'b0; step();
    chk("R11 bb_o during wait", bb_o, 1);
    ta = 1'b1; step(); ta = 1'b0;
    int_req = 1'b0;
    repeat (4) step();
    chk("R3 grant held without request", int_gnt_o, 1);

    // external request latency
    ext_br = 1'b1;
    step(); chk("R2 no grant after one edge", ext_bg_o, 0);
    step(); chk("R2 grant after second edge", ext_bg_o, 1);
    chk("R11 drive released", bb_oe_o, 0);
    ext_take();
    repeat (3) step();
    chk("R10 bus idle after release", int_gnt_o + ext_bg_o, 0);

    // equal tie from idle, last user external
    int_req = 1'b1; ext_br = 1'b1;
    step(); step();
    chk("R5 tie to internal", int_gnt_o, 1);
    int_xfer(0);
    step();
    chk("R6 yield after transaction", ext_bg_o, 1);
    chk("R6 internal lost grant", int_gnt_o, 0);
    ext_take();
    chk("R5 internal regains", int_gnt_o, 1);

    // internal-first at a boundary where LRU would choose external
    int_xfer(0);
    cfg = 2'b01; ext_br = 1'b1;
    repeat (4) step();
    chk("R7 internal kept", int_gnt_o, 1);
    chk("R7 no grant to external", ext_bg_o, 0);
    int_req = 1'b0;
    step(); step();
    chk("R7 external after internal drops", ext_bg_o, 1);
    ext_take();

    // external-first tie from idle where LRU would choose internal
    cfg = 2'b10; int_req = 1'b1; ext_br = 1'b1;
    step(); step();
    chk("R8 tie to external", ext_bg_o, 1);
    chk("R8 internal waits", int_gnt_o, 0);
    ext_take();
    chk("R8 internal after release", int_gnt_o, 1);

    // pre-emption attempt during wait states
    ts = 1'b1; ext_br = 1'b1; step(); ts = 1'b0;
    for (int i = 0; i < 8; i++) begin
      step();
      chk("R9 no grant during wait states", ext_bg_o, 0);
    end
    ta = 1'b1; step(); ta = 1'b0;
    chk("R9 no grant at acknowledge edge", ext_bg_o, 0);
    step();
    chk("R8 grant at boundary", ext_bg_o, 1);
    ext_take();

    // an issued grant is not withdrawn
    cfg = 2'b01; int_req = 1'b0; ext_br = 1'b1;
    for (int i = 0; i < 20 && !ext_bg_o; i++) step();
    int_req = 1'b1;
    repeat (3) begin
      step();
      chk("R9 grant held", ext_bg_o, 1);
      chk("R9 internal held off", int_gnt_o, 0);
    end
    ext_take();
    chk("R7 internal after release", int_gnt_o, 1);

    // setting 11 behaves as equal
    int_xfer(0);
    cfg = 2'b11; ext_br = 1'b1;
    step(); step();
    chk("R5 code 11 acts as equal", ext_bg_o, 1);
    ext_take();
    int_req = 1'b0;
    repeat (4) step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule